// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single-byte bus requests into correctly timed strobe sequences on an asynchronous NAND flash interface. A request names one of five cycle kinds: command latch, address latch, data write, data read, or wait-for-ready. It carries one byte. The block then walks through a fixed order of timed phases for that kind. It drives chip enable, write enable, read enable and the two latch-enable lines, and it opens the data bus output enable only while the byte must be on the wires.

Every phase length is a clock-tick count taken from two 32-bit timing words. Each word holds four 8-bit fields. A field of zero removes its phase entirely. A read cycle samples the data bus inside the read-enable low window and returns the byte together with a one-cycle completion pulse. A wait-for-ready cycle watches the synchronized ready/busy pin and gives up after a programmable number of cycles, raising a sticky error.

Requests use a valid/ready handshake. The block accepts a new request only while it is idle, so `req_ready` falls for the whole of a bus cycle, and that is the only back-pressure it applies. The completion pulse `rsp_valid` cannot be stalled, so the consumer must take `rsp_byte` in the cycle it is high.

Top module: `nand_strobe_seq`

## Requirements
- R1: Out of reset and while idle: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1; `nand_cle`, `nand_ale`, `nand_dq_oe`, `rsp_valid` and `err_timeout` are 0; `req_ready` is 1.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in the idle state, so it stays 0 from acceptance until the cycle after `rsp_valid`. Kind codes on `req_kind` are: 0 command, 1 address, 2 data write, 3 data read, 4 wait-for-ready.
- R3: Timing field positions. In `timing_a`, bits [31:24] hold the CE-to-strobe setup, [23:16] the post-write wait, [15:8] the whole write cycle and [7:0] the write-enable low count. In `timing_b`, bits [31:24] hold the read access delay, [23:16] the read-enable high hold, [15:8] the read-enable low count and [7:0] the read turnaround.
- R4: A command, address or data write cycle has four phases in order. First, CE is low for the setup count. Next, WE is low for the low count. Then WE is high for the write cycle count minus the low count, or zero if that is negative. Last comes the post-write wait. `nand_dq_out` carries the request byte, and `nand_dq_oe` is 1 during the first three phases and 0 in the wait.
- R5: `nand_cle` is 1 for every CE-low cycle of a command cycle, and `nand_ale` is 1 for every CE-low cycle of an address cycle. Neither is 1 during data or wait-for-ready cycles.
- R6: A phase whose count is zero takes no cycles. `rsp_valid` goes high exactly (sum of the phase lengths + 1) clock cycles after the accepting edge.
- R7: A read cycle holds CE low for the setup count, then RE low for max(low count, access delay + 1) cycles. It samples `nand_dq_in` at the clock edge that ends the RE-low cycle with index equal to the access delay, counting from 0. The sampled byte appears on `rsp_byte` while `rsp_valid` is 1.
- R8: After RE low, a read cycle holds RE high for the hold count and then runs the turnaround count before completing. `nand_dq_oe` stays 0 throughout a read cycle.
- R9: `nand_rb` passes through a 2-stage synchronizer. A wait-for-ready cycle completes in the cycle after the synchronized value is 1. When `nand_rb` is already stable high, `rsp_valid` appears 2 cycles after acceptance.
- R10: A wait-for-ready cycle that does not see ready completes after `timeout_limit` + 1 cycles in the wait state. It sets `err_timeout` on the same edge that raises `rsp_valid`.
- R11: `err_timeout` stays 1 until `err_clear` is sampled high. A new timeout in the same cycle wins over the clear.
- R12: `timing_a`, `timing_b` and `timeout_limit` are captured on the accepting edge. Changes during a cycle have no effect on that cycle.
- R13: Kind codes 5 to 7 toggle no NAND pin, and `rsp_valid` rises one cycle after acceptance.
- R14: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_a | input | 32 | Write-side tick fields (R3) |
| timing_b | input | 32 | Read-side tick fields (R3) |
| timeout_limit | input | 16 | Wait-for-ready cycle limit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_kind | input | 3 | Cycle kind code |
| req_byte | input | 8 | Command, address or write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_byte | output | 8 | Byte sampled by the latest read cycle |
| err_timeout | output | 1 | Sticky wait-for-ready timeout flag |
| err_clear | input | 1 | Clears the timeout flag |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
The bench goes after zero-length phases, a write-low count larger than the write cycle count, and a read access delay longer than the read-enable low count. A design that mishandled these would add stray cycles, wrap the high phase to a huge count, or sample the bus after RE has risen. The bench counts cycles of every strobe and measures completion latency. A read byte that changes on every RE-low cycle shows exactly which cycle was sampled, so sampling one cycle early or late returns the wrong byte. Separate runs change the timing words in the middle of a cycle, raise ready after an arbitrary delay, and let the timeout expire. These catch a design that picks up timing words mid-cycle, drops a synchronizer stage, or lets the error flag clear itself.

// File: rtl/nss_pkg.sv
package nss_pkg;
  localparam int KIND_W = 3;
  localparam int NSLOT  = 4;

  localparam logic [KIND_W-1:0] KD_CMD   = 3'd0;
  localparam logic [KIND_W-1:0] KD_ADDR  = 3'd1;
  localparam logic [KIND_W-1:0] KD_WRITE = 3'd2;
  localparam logic [KIND_W-1:0] KD_READ  = 3'd3;
  localparam logic [KIND_W-1:0] KD_WAIT  = 3'd4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_S0, PH_S1, PH_S2, PH_S3, PH_WAIT, PH_DONE
  } phase_t;

  function automatic logic strobe_kind(input logic [KIND_W-1:0] k);
    return k <= KD_READ;
  endfunction

  function automatic logic write_kind(input logic [KIND_W-1:0] k);
    return k <= KD_WRITE;
  endfunction

  function automatic phase_t slot_ph(input int k);
    case (k)
      0:       return PH_S0;
      1:       return PH_S1;
      2:       return PH_S2;
      default: return PH_S3;
    endcase
  endfunction
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/nss_timing_shadow.sv
module nss_timing_shadow
  import nss_pkg::*;
#(
  parameter int TICK_W = 8,
  parameter int TO_W   = 16,
  localparam int REG_W = NSLOT * TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [REG_W-1:0]  ta_in,
  input  logic [REG_W-1:0]  tb_in,
  input  logic [TO_W-1:0]   lim_in,
  output logic [TICK_W-1:0] fld_a [NSLOT],
  output logic [TICK_W-1:0] fld_b [NSLOT],
  output logic [TO_W-1:0]   lim_out
);
  logic [REG_W-1:0] ta_q, tb_q, ta_eff, tb_eff;
  logic [TO_W-1:0]  lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q  <= '0;
      tb_q  <= '0;
      lim_q <= '0;
    end else if (load) begin
      ta_q  <= ta_in;
      tb_q  <= tb_in;
      lim_q <= lim_in;
    end
  end

  // On the accepting edge the live words steer the first decision.
  assign ta_eff  = load ? ta_in  : ta_q;
  assign tb_eff  = load ? tb_in  : tb_q;
  assign lim_out = load ? lim_in : lim_q;

  // Field 0 sits in the top byte.
  for (genvar i = 0; i < NSLOT; i++) begin : g_fld
    assign fld_a[i] = ta_eff[(NSLOT-i)*TICK_W-1 -: TICK_W];
    assign fld_b[i] = tb_eff[(NSLOT-i)*TICK_W-1 -: TICK_W];
  end
endmodule

// File: rtl/nss_slot_plan.sv
module nss_slot_plan
  import nss_pkg::*;
#(
  parameter int TICK_W = 8,
  localparam int LEN_W = TICK_W + 1
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [TICK_W-1:0] fld_a [NSLOT],
  input  logic [TICK_W-1:0] fld_b [NSLOT],
  output logic [LEN_W-1:0]  lens  [NSLOT],
  output logic [TICK_W-1:0] samp_idx
);
  logic [LEN_W-1:0] ce_set, wr_busy, wr_cyc, wr_low;
  logic [LEN_W-1:0] rd_acc, rd_hold, rd_low, rd_turn;
  logic [LEN_W-1:0] wr_high, rd_low_eff, acc_p1;

  assign ce_set  = {1'b0, fld_a[0]};
  assign wr_busy = {1'b0, fld_a[1]};
  assign wr_cyc  = {1'b0, fld_a[2]};
  assign wr_low  = {1'b0, fld_a[3]};
  assign rd_acc  = {1'b0, fld_b[0]};
  assign rd_hold = {1'b0, fld_b[1]};
  assign rd_low  = {1'b0, fld_b[2]};
  assign rd_turn = {1'b0, fld_b[3]};

  assign wr_high    = (wr_cyc > wr_low) ? (wr_cyc - wr_low) : '0;
  assign acc_p1     = rd_acc + LEN_W'(1);
  assign rd_low_eff = (rd_low > acc_p1) ? rd_low : acc_p1;
  assign samp_idx   = fld_b[0];

  always_comb begin
    lens[0] = ce_set;
    if (kind == KD_READ) begin
      lens[1] = rd_low_eff;
      lens[2] = rd_hold;
      lens[3] = rd_turn;
    end else begin
      lens[1] = wr_low;
      lens[2] = wr_high;
      lens[3] = wr_busy;
    end
  end
endmodule

// File: rtl/nss_seq.sv
module nss_seq
  import nss_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int TO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KIND_W-1:0] kind,
  input  logic [LEN_W-1:0]  lens [NSLOT],
  input  logic              rb_ok,
  input  logic [TO_W-1:0]   lim,
  output phase_t            ph,
  output logic [LEN_W-1:0]  cnt,
  output logic              tmo_evt
);
  phase_t           ph_q, next_ph;
  phase_t           from_slot [NSLOT+1];
  logic [LEN_W-1:0] cnt_q, cur_len;
  logic [TO_W-1:0]  wcnt_q;

  // First non-empty slot at or after each index.
  always_comb begin
    for (int s = 0; s <= NSLOT; s++) begin
      from_slot[s] = PH_DONE;
      for (int k = NSLOT-1; k >= 0; k--)
        if (k >= s && lens[k] != '0) from_slot[s] = slot_ph(k);
    end
  end

  always_comb begin
    cur_len = lens[0];
    next_ph = PH_DONE;
    case (ph_q)
      PH_S0: begin cur_len = lens[0]; next_ph = from_slot[1]; end
      PH_S1: begin cur_len = lens[1]; next_ph = from_slot[2]; end
      PH_S2: begin cur_len = lens[2]; next_ph = from_slot[3]; end
      PH_S3: begin cur_len = lens[3]; next_ph = from_slot[4]; end
      default: ;
    endcase
  end

  assign tmo_evt = (ph_q == PH_WAIT) && !rb_ok && (wcnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wcnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          cnt_q  <= '0;
          wcnt_q <= '0;
          if (strobe_kind(kind))  ph_q <= from_slot[0];
          else if (kind == KD_WAIT) ph_q <= PH_WAIT;
          else                    ph_q <= PH_DONE;
        end
        PH_WAIT: begin
          if (rb_ok || wcnt_q == lim) ph_q <= PH_DONE;
          else                        wcnt_q <= wcnt_q + 1'b1;
        end
        PH_DONE: ph_q <= PH_IDLE;
        default: begin
          if (cnt_q == cur_len - 1'b1) begin
            cnt_q <= '0;
            ph_q  <= next_ph;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ph  = ph_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nss_pkg::*;
#(
  parameter int TICK_W    = 8,
  parameter int DATA_W    = 8,
  parameter int TO_W      = 16,
  parameter int RB_STAGES = 2,
  localparam int REG_W    = NSLOT * TICK_W,
  localparam int LEN_W    = TICK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  timing_a,
  input  logic [REG_W-1:0]  timing_b,
  input  logic [TO_W-1:0]   timeout_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [DATA_W-1:0] req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_byte,
  output logic              err_timeout,
  input  logic              err_clear,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);
  logic              accept, rb_ok, tmo_evt, in_slot, samp_now;
  logic [KIND_W-1:0] kind_q, kind_eff;
  logic [DATA_W-1:0] byte_q, rd_q;
  logic              err_q;
  logic [TICK_W-1:0] fld_a [NSLOT];
  logic [TICK_W-1:0] fld_b [NSLOT];
  logic [LEN_W-1:0]  slot_len [NSLOT];
  logic [TICK_W-1:0] samp_idx;
  logic [TO_W-1:0]   lim;
  logic [LEN_W-1:0]  cnt;
  phase_t            ph;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign kind_eff  = accept ? req_kind : kind_q;

  nss_timing_shadow #(.TICK_W(TICK_W), .TO_W(TO_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .ta_in(timing_a), .tb_in(timing_b), .lim_in(timeout_limit),
    .fld_a(fld_a), .fld_b(fld_b), .lim_out(lim)
  );

  nss_slot_plan #(.TICK_W(TICK_W)) u_plan (
    .kind(kind_eff), .fld_a(fld_a), .fld_b(fld_b),
    .lens(slot_len), .samp_idx(samp_idx)
  );

  nss_sync #(.STAGES(RB_STAGES)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_ok)
  );

  nss_seq #(.LEN_W(LEN_W), .TO_W(TO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .kind(kind_eff),
    .lens(slot_len), .rb_ok(rb_ok), .lim(lim),
    .ph(ph), .cnt(cnt), .tmo_evt(tmo_evt)
  );

  assign samp_now = (ph == PH_S1) && (kind_q == KD_READ) && (cnt == {1'b0, samp_idx});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      byte_q <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        kind_q <= req_kind;
        byte_q <= req_byte;
      end
      if (samp_now) rd_q <= nand_dq_in;
      if (tmo_evt)        err_q <= 1'b1;
      else if (err_clear) err_q <= 1'b0;
    end
  end

  assign in_slot     = (ph == PH_S0) || (ph == PH_S1) || (ph == PH_S2) || (ph == PH_S3);
  assign nand_ce_n   = !in_slot;
  assign nand_cle    = in_slot && (kind_q == KD_CMD);
  assign nand_ale    = in_slot && (kind_q == KD_ADDR);
  assign nand_we_n   = !((ph == PH_S1) && write_kind(kind_q));
  assign nand_re_n   = !((ph == PH_S1) && (kind_q == KD_READ));
  assign nand_dq_oe  = write_kind(kind_q) &&
                       ((ph == PH_S0) || (ph == PH_S1) || (ph == PH_S2));
  assign nand_dq_out = byte_q;

  assign rsp_valid   = (ph == PH_DONE);
  assign rsp_byte    = rd_q;
  assign err_timeout = err_q;
endmodule

// File: rtl/nss_checker.sv
module nss_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              re_n,
  input logic              cle,
  input logic              ale,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              err,
  input logic              err_clear
);
  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n); // R4
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R7
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe); // R8
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R5
  AST_DQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dq_out)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R14
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && !rsp_valid)); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clear) |=> err); // R11
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> rsp_valid); // R10
endmodule

bind nand_strobe_seq nss_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .we_n(nand_we_n),
  .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale), .dq_oe(nand_dq_oe),
  .dq_out(nand_dq_out), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .err(err_timeout), .err_clear(err_clear)
);

// File: tb/nand_strobe_seq_tb.sv
`timescale 1ns/1ps
module nand_strobe_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_a = '0, timing_b = '0;
  logic [15:0] timeout_limit = 16'd20;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_kind = '0;
  logic [7:0]  req_byte = '0;
  logic        rsp_valid, err_timeout, err_clear = 1'b0;
  logic [7:0]  rsp_byte, nand_dq_out, nand_dq_in = '0;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic        nand_rb = 1'b0;

  always #2.5 clk = ~clk;

  nand_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .timing_a(timing_a), .timing_b(timing_b),
    .timeout_limit(timeout_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte), .err_timeout(err_timeout), .err_clear(err_clear),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  int n_chk = 0, n_bad = 0;
  int m_lat, m_ce, m_we, m_re, m_oe, m_cle, m_ale, m_rdy, m_after, m_rdy_after;
  logic [7:0] m_byte, m_wdat;

  // kind, byte, timing_a, timing_b
  localparam int NV = 8;
  localparam logic [74:0] VEC [NV] = '{
    {3'd0, 8'h70, 32'h02010503, 32'h00000000},
    {3'd1, 8'h1C, 32'h01000202, 32'h00000000},
    {3'd2, 8'hA5, 32'h00030401, 32'h00000000},
    {3'd3, 8'h40, 32'h02000000, 32'h03020201},
    {3'd3, 8'h10, 32'h01000000, 32'h01000503},
    {3'd0, 8'h99, 32'h00000000, 32'h00000000},
    {3'd2, 8'h3C, 32'h00000004, 32'h00000000},
    {3'd3, 8'hF0, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] k, input logic [7:0] b,
                         input logic [31:0] ta, input logic [31:0] tb,
                         input bit swap, input int rb_at);
    m_lat = 0; m_ce = 0; m_we = 0; m_re = 0; m_oe = 0; m_cle = 0; m_ale = 0;
    m_rdy = 0; m_byte = '0; m_wdat = '0;
    @(negedge clk);
    timing_a = ta; timing_b = tb; req_kind = k; req_byte = b;
    nand_dq_in = b; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (swap) begin timing_a = 32'h05050505; timing_b = 32'h05050505; end
    for (int n = 1; n <= 4000; n++) begin
      if (rb_at == n) nand_rb = 1'b1;
      m_lat = n;
      if (!nand_ce_n) m_ce++;
      if (!nand_we_n) begin m_we++; m_wdat = nand_dq_out; end
      if (!nand_re_n) begin m_re++; nand_dq_in = b + 8'(m_re); end
      if (nand_dq_oe) m_oe++;
      if (nand_cle) m_cle++;
      if (nand_ale) m_ale++;
      if (req_ready) m_rdy++;
      if (rsp_valid) begin m_byte = rsp_byte; break; end
      @(negedge clk);
    end
    @(negedge clk);
    m_after = int'(rsp_valid);
    m_rdy_after = int'(req_ready);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 idle pins under reset and after release
    chk("R1 ce_n in reset", int'(nand_ce_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    chk("R1 idle latches/oe", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
    chk("R1 idle ready", int'(req_ready), 1);
    chk("R1 idle rsp/err", int'({rsp_valid, err_timeout}), 0);

    // Vector walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  k;
      logic [7:0]  b;
      logic [31:0] ta, tb;
      int ce, wb, wc, wp, rea, reh, rp, rhz, hi, low, tot;
      {k, b, ta, tb} = VEC[v];
      ce = ta[31:24]; wb = ta[23:16]; wc = ta[15:8]; wp = ta[7:0];
      rea = tb[31:24]; reh = tb[23:16]; rp = tb[15:8]; rhz = tb[7:0];
      hi  = (wc > wp) ? wc - wp : 0;
      low = (rp > rea + 1) ? rp : rea + 1;
      run_req(k, b, ta, tb, 1'b0, 0);
      if (k == 3'd3) begin
        tot = ce + low + reh + rhz;
        chk("R7 re low cycles", m_re, low);
        chk("R7 sampled byte", int'(m_byte), (int'(b) + rea + 1) % 256);
        chk("R8 no drive in read", m_oe, 0);
        chk("R8 no we in read", m_we, 0);
      end else begin
        tot = ce + wp + hi + wb;
        chk("R4 we low cycles", m_we, wp);
        chk("R4 oe cycles", m_oe, ce + wp + hi);
        if (wp > 0) chk("R4 dq byte", int'(m_wdat), int'(b));
        chk("R5 cle cycles", m_cle, (k == 3'd0) ? tot : 0);
        chk("R5 ale cycles", m_ale, (k == 3'd1) ? tot : 0);
      end
      chk("R3 ce low cycles", m_ce, tot);
      chk("R6 latency", m_lat, tot + 1);
      chk("R2 busy not ready", m_rdy, 0);
      chk("R2 ready after", m_rdy_after, 1);
      chk("R14 single pulse", m_after, 0);
    end

    // R12 timing changed mid-cycle is ignored
    run_req(3'd2, 8'h5A, 32'h01020304, 32'h0, 1'b1, 0);
    chk("R12 latency frozen", m_lat, 1 + 4 + 0 + 2 + 1);
    chk("R12 we frozen", m_we, 4);

    // R13 reserved kind
    run_req(3'd6, 8'h00, 32'h04040404, 32'h04040404, 1'b0, 0);
    chk("R13 latency", m_lat, 1);
    chk("R13 no pins", m_ce + m_we + m_re + m_oe + m_cle + m_ale, 0);

    // R9 ready already high
    nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    run_req(3'd4, 8'h00, 32'h0, 32'h0, 1'b0, 0);
    chk("R9 ready immediate", m_lat, 2);
    chk("R9 no ce in wait", m_ce, 0);
    // R9 ready rising mid-wait
    nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    run_req(3'd4, 8'h00, 32'h0, 32'h0, 1'b0, 3);
    chk("R9 sync latency", m_lat, 6);
    chk("R9 no error", int'(err_timeout), 0);

    // R10 timeout
    nand_rb = 1'b0;
    timeout_limit = 16'd5;
    repeat (3) @(negedge clk);
    run_req(3'd4, 8'h00, 32'h0, 32'h0, 1'b0, 0);
    chk("R10 timeout latency", m_lat, 7);
    chk("R10 error set", int'(err_timeout), 1);
    // R11 sticky through time and another cycle
    repeat (4) @(negedge clk);
    run_req(3'd0, 8'hFF, 32'h01010101, 32'h0, 1'b0, 0);
    chk("R11 error sticky", int'(err_timeout), 1);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk("R11 error cleared", int'(err_timeout), 0);

    finish_run();
  end
endmodule